// File: doc/BRIEF.md
# Condition Register Compare Update Unit

This block keeps a 32-bit condition register built from eight 4-bit flag fields. Each field holds a less-than flag, a greater-than flag, an equal flag and a copy of the summary-overflow bit. A compare operation writes its result into any one of the eight fields. A record-form arithmetic result writes field 0. A move-to operation can overwrite any set of fields through a per-field mask.

A compare sets exactly one of its three relation flags. Operand A is compared with either operand B or a 16-bit immediate. The comparison is signed or unsigned. The immediate is sign-extended for a signed compare and zero-extended for an unsigned one. In every write, the summary-overflow flag is copied from the exception-register bit presented in the same cycle as the strobe.

All updates are synchronous. Two indexed read ports return single fields combinationally. The whole register is also available as one word. Floating-point activity never writes any field, field 1 included.

Top module: `cond_reg_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe, `cr_out` reads 0.
- R2: Field n occupies `cr_out[31-4n:28-4n]`, so field 0 is the top nibble. Inside a field, bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO. Mask bit n of `mt_mask` selects field n.
- R3: A signed compare (`cmp_signed`=1) treats A and the second operand as two's complement. It sets exactly one of LT, GT and EQ in the target field.
- R4: An unsigned compare (`cmp_signed`=0) treats both operands as unsigned magnitudes. It sets exactly one of LT, GT and EQ.
- R5: With `cmp_use_imm`=1 the second operand is `cmp_imm`, sign-extended when signed and zero-extended when unsigned, and `cmp_b` has no effect.
- R6: The SO bit of every field written by a compare or a record is the value of `xer_so` in the strobe cycle.
- R7: `rec_valid` writes field 0 as follows: LT when `rec_result` is negative, GT when it is nonzero and positive, EQ when it is zero, and SO from `xer_so`.
- R8: When a compare targets field 0 in the same cycle as a record, the compare's result is written. A compare to another field and a record in the same cycle both take effect.
- R9: `mt_valid` loads every field whose mask bit is set from the matching nibble of `mt_value`. A compare or record to the same field in that cycle overrides the move.
- R10: An update appears on `cr_out` after the first rising clock edge that samples the strobe, and not before. With no strobe the register holds.
- R11: Read port p returns, in the same cycle, the field selected by `rd_sel[3p+2:3p]` on `rd_field[4p+3:4p]`.
- R12: Fields that no strobe selects keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_valid | input | 1 | Compare strobe |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_use_imm | input | 1 | 1 = compare against the immediate instead of `cmp_b` |
| cmp_field | input | 3 | Target field of the compare |
| cmp_a | input | 32 | Operand A |
| cmp_b | input | 32 | Register operand B |
| cmp_imm | input | 16 | Immediate operand |
| rec_valid | input | 1 | Record-form result strobe (writes field 0) |
| rec_result | input | 32 | Arithmetic result to evaluate |
| xer_so | input | 1 | Current summary-overflow bit |
| mt_valid | input | 1 | Move-to strobe |
| mt_mask | input | 8 | Field mask, bit n selects field n |
| mt_value | input | 32 | Value for the move-to |
| rd_sel | input | 6 | Field indices of the two read ports |
| cr_out | output | 32 | Whole condition register |
| rd_field | output | 8 | Read port fields, port 0 in bits 3:0 |

## Verification
Register writes from a compare, a record or a move become visible one rising edge after the strobe is sampled. The bench therefore drives on the falling edge and compares the whole register on the next falling edge. In one case it also samples 1 ns after driving, to confirm that the old value is still present. Read ports are combinational, so they are checked in the same cycle their select changes, with no edge in between.

The operand sweep covers every pair from a set of eight boundary values. Each pair runs in all four combinations of signed/unsigned and register/immediate, and the target field and `xer_so` rotate across the sweep. Each compare is checked against a 64-bit arithmetic model of that compare.

// File: rtl/cru_pkg.sv
package cru_pkg;

  localparam int FLAG_W = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_flags_t;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_MOVE = 2'd1,
    SRC_REC  = 2'd2,
    SRC_CMP  = 2'd3
  } field_src_e;

endpackage

// File: rtl/cru_rst_sync.sv
module cru_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/cru_compare.sv
module cru_compare #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              is_signed,
  output logic              lt,
  output logic              gt,
  output logic              eq
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic              ext_bit;
  logic [DATA_W-1:0] opb_sel;
  logic [DATA_W-1:0] opa_bias;
  logic [DATA_W-1:0] opb_bias;

  // Immediate extension: sign bit only participates in signed mode.
  always_comb begin
    ext_bit = is_signed & imm[IMM_W-1];
    if (use_imm) begin
      opb_sel = {{EXT_W{ext_bit}}, imm};
    end else begin
      opb_sel = opb;
    end
  end

  // Flipping the top bit in signed mode maps two's complement ordering
  // onto unsigned ordering, so one magnitude comparator serves both modes.
  always_comb begin
    opa_bias = {opa[DATA_W-1] ^ is_signed, opa[DATA_W-2:0]};
    opb_bias = {opb_sel[DATA_W-1] ^ is_signed, opb_sel[DATA_W-2:0]};
    eq = (opa == opb_sel);
    lt = (opa_bias < opb_bias);
    gt = ~lt & ~eq;
  end

endmodule

// File: rtl/cru_record_eval.sv
module cru_record_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  output logic              neg,
  output logic              pos,
  output logic              zero
);

  always_comb begin
    zero = ~|result;
    neg  = result[DATA_W-1];
    pos  = ~neg & ~zero;
  end

endmodule

// File: rtl/cru_field_next.sv
module cru_field_next
  import cru_pkg::*;
(
  input  logic      cmp_hit,
  input  logic      rec_hit,
  input  logic      mt_hit,
  input  cr_flags_t cmp_flags,
  input  cr_flags_t rec_flags,
  input  cr_flags_t mt_flags,
  output cr_flags_t nxt_flags,
  output logic      wr_en
);

  field_src_e src;

  // Priority: compare, then record, then move-to.
  always_comb begin
    if (cmp_hit) begin
      src = SRC_CMP;
    end else if (rec_hit) begin
      src = SRC_REC;
    end else if (mt_hit) begin
      src = SRC_MOVE;
    end else begin
      src = SRC_HOLD;
    end
  end

  always_comb begin
    wr_en = (src != SRC_HOLD);
    case (src)
      SRC_CMP:  nxt_flags = cmp_flags;
      SRC_REC:  nxt_flags = rec_flags;
      SRC_MOVE: nxt_flags = mt_flags;
      default:  nxt_flags = '0;
    endcase
  end

endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
  import cru_pkg::*;
#(
  parameter int  NUM_FIELDS = 8,
  parameter int  DATA_W     = 32,
  parameter int  IMM_W      = 16,
  parameter int  NUM_RD     = 2,
  localparam int SEL_W      = $clog2(NUM_FIELDS),
  localparam int CR_W       = NUM_FIELDS * FLAG_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmp_valid,
  input  logic                    cmp_signed,
  input  logic                    cmp_use_imm,
  input  logic [SEL_W-1:0]        cmp_field,
  input  logic [DATA_W-1:0]       cmp_a,
  input  logic [DATA_W-1:0]       cmp_b,
  input  logic [IMM_W-1:0]        cmp_imm,
  input  logic                    rec_valid,
  input  logic [DATA_W-1:0]       rec_result,
  input  logic                    xer_so,
  input  logic                    mt_valid,
  input  logic [NUM_FIELDS-1:0]   mt_mask,
  input  logic [CR_W-1:0]         mt_value,
  input  logic [NUM_RD*SEL_W-1:0] rd_sel,
  output logic [CR_W-1:0]         cr_out,
  output logic [NUM_RD*FLAG_W-1:0] rd_field
);

  logic      rst_sync_n;
  logic      cmp_lt, cmp_gt, cmp_eq;
  logic      rec_neg, rec_pos, rec_zero;
  cr_flags_t cmp_flags;
  cr_flags_t rec_flags;
  cr_flags_t field_q   [NUM_FIELDS];
  cr_flags_t field_nxt [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] field_en;

  cru_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  cru_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_compare (
    .opa       (cmp_a),
    .opb       (cmp_b),
    .imm       (cmp_imm),
    .use_imm   (cmp_use_imm),
    .is_signed (cmp_signed),
    .lt        (cmp_lt),
    .gt        (cmp_gt),
    .eq        (cmp_eq)
  );

  cru_record_eval #(.DATA_W(DATA_W)) u_record (
    .result (rec_result),
    .neg    (rec_neg),
    .pos    (rec_pos),
    .zero   (rec_zero)
  );

  always_comb begin
    cmp_flags = '{lt: cmp_lt,  gt: cmp_gt,  eq: cmp_eq,   so: xer_so};
    rec_flags = '{lt: rec_neg, gt: rec_pos, eq: rec_zero, so: xer_so};
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int HI = CR_W - 1 - FLAG_W * f;

    logic      hit_cmp;
    logic      hit_rec;
    logic      hit_mt;
    cr_flags_t mt_flags;

    always_comb begin
      hit_cmp  = cmp_valid && (cmp_field == SEL_W'(f));
      hit_mt   = mt_valid && mt_mask[f];
      mt_flags = cr_flags_t'(mt_value[HI -: FLAG_W]);
    end

    // Only field 0 listens to record-form results.
    if (f == 0) begin : g_rec
      assign hit_rec = rec_valid;
    end else begin : g_norec
      assign hit_rec = 1'b0;
    end

    cru_field_next u_next (
      .cmp_hit   (hit_cmp),
      .rec_hit   (hit_rec),
      .mt_hit    (hit_mt),
      .cmp_flags (cmp_flags),
      .rec_flags (rec_flags),
      .mt_flags  (mt_flags),
      .nxt_flags (field_nxt[f]),
      .wr_en     (field_en[f])
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        field_q[f] <= '0;
      end else if (field_en[f]) begin
        field_q[f] <= field_nxt[f];
      end
    end

    assign cr_out[HI -: FLAG_W] = field_q[f];
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [SEL_W-1:0] idx;
    assign idx = rd_sel[p*SEL_W +: SEL_W];
    assign rd_field[p*FLAG_W +: FLAG_W] = field_q[idx];
  end

endmodule

// File: rtl/cond_reg_chk.sv
module cond_reg_chk #(
  parameter int  NUM_FIELDS = 8,
  parameter int  DATA_W     = 32,
  localparam int SEL_W      = $clog2(NUM_FIELDS),
  localparam int CR_W       = NUM_FIELDS * 4
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic                  cmp_valid,
  input logic [SEL_W-1:0]      cmp_field,
  input logic                  rec_valid,
  input logic [DATA_W-1:0]     rec_result,
  input logic                  xer_so,
  input logic                  mt_valid,
  input logic [NUM_FIELDS-1:0] mt_mask,
  input logic [CR_W-1:0]       mt_value,
  input logic [CR_W-1:0]       cr_out
);

  logic [SEL_W-1:0] last_f;
  logic [3:0]       tgt_nib;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      last_f <= '0;
    end else begin
      last_f <= cmp_field;
    end
  end

  assign tgt_nib = cr_out[CR_W-1-4*last_f -: 4];

  // R3
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_valid |=> ($countones(tgt_nib[3:1]) == 1));

  // R6
  cmp_so_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_valid |=> (tgt_nib[0] == $past(xer_so)));

  // R7
  rec_sign_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rec_valid && !(cmp_valid && cmp_field == '0))
      |=> (cr_out[CR_W-1] == $past(rec_result[DATA_W-1])));

  // R7
  rec_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rec_valid && !(cmp_valid && cmp_field == '0))
      |=> (cr_out[CR_W-3] == ($past(rec_result) == '0)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cmp_valid && !rec_valid && !mt_valid) |=> $stable(cr_out));

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fchk
    localparam int HI = CR_W - 1 - 4 * f;
    logic cmp_here;
    logic rec_here;
    assign cmp_here = cmp_valid && (cmp_field == SEL_W'(f));
    assign rec_here = (f == 0) && rec_valid;

    // R9
    mt_field_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (mt_valid && mt_mask[f] && !cmp_here && !rec_here)
        |=> (cr_out[HI -: 4] == $past(mt_value[HI -: 4])));

    // R12
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (!cmp_here && !rec_here && !(mt_valid && mt_mask[f]))
        |=> $stable(cr_out[HI -: 4]));
  end

endmodule

bind cond_reg_unit cond_reg_chk #(
  .NUM_FIELDS (NUM_FIELDS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .cmp_valid  (cmp_valid),
  .cmp_field  (cmp_field),
  .rec_valid  (rec_valid),
  .rec_result (rec_result),
  .xer_so     (xer_so),
  .mt_valid   (mt_valid),
  .mt_mask    (mt_mask),
  .mt_value   (mt_value),
  .cr_out     (cr_out)
);

// File: tb/cond_reg_unit_bench.sv
module cond_reg_unit_bench;

  localparam int NF = 8;
  localparam int DW = 32;
  localparam int IW = 16;
  localparam int NR = 2;
  localparam int CW = NF * 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           cmp_valid, cmp_signed, cmp_use_imm;
  logic [2:0]     cmp_field;
  logic [DW-1:0]  cmp_a, cmp_b;
  logic [IW-1:0]  cmp_imm;
  logic           rec_valid;
  logic [DW-1:0]  rec_result;
  logic           xer_so;
  logic           mt_valid;
  logic [NF-1:0]  mt_mask;
  logic [CW-1:0]  mt_value;
  logic [NR*3-1:0] rd_sel;
  logic [CW-1:0]  cr_out;
  logic [NR*4-1:0] rd_field;

  int n_chk  = 0;
  int n_fail = 0;
  logic [CW-1:0] exp_cr;

  cond_reg_unit u_cond_reg_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_valid   (cmp_valid),
    .cmp_signed  (cmp_signed),
    .cmp_use_imm (cmp_use_imm),
    .cmp_field   (cmp_field),
    .cmp_a       (cmp_a),
    .cmp_b       (cmp_b),
    .cmp_imm     (cmp_imm),
    .rec_valid   (rec_valid),
    .rec_result  (rec_result),
    .xer_so      (xer_so),
    .mt_valid    (mt_valid),
    .mt_mask     (mt_mask),
    .mt_value    (mt_value),
    .rd_sel      (rd_sel),
    .cr_out      (cr_out),
    .rd_field    (rd_field)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [3:0] get_f(input logic [CW-1:0] v, input int i);
    return v[CW-1-4*i -: 4];
  endfunction

  function automatic logic [CW-1:0] put_f(input logic [CW-1:0] v, input int i,
                                          input logic [3:0] n);
    logic [CW-1:0] r;
    r = v;
    r[CW-1-4*i -: 4] = n;
    return r;
  endfunction

  // 64-bit arithmetic model of a compare: {LT,GT,EQ,SO}
  function automatic logic [3:0] model_cmp(input logic [31:0] a, input logic [31:0] b,
                                           input logic [15:0] imm, input bit use_imm,
                                           input bit sgn, input bit so);
    longint va, vb;
    va = sgn ? longint'($signed(a)) : longint'({32'b0, a});
    if (use_imm) vb = sgn ? longint'($signed(imm)) : longint'({48'b0, imm});
    else         vb = sgn ? longint'($signed(b))   : longint'({32'b0, b});
    return {va < vb, va > vb, va == vb, so};
  endfunction

  function automatic logic [3:0] model_rec(input logic [31:0] r, input bit so);
    longint v;
    v = longint'($signed(r));
    return {v < 0, v > 0, v == 0, so};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cmp_valid = 1'b0; rec_valid = 1'b0; mt_valid = 1'b0;
  endtask

  task automatic do_cmp(input int fld, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] imm, input bit use_imm, input bit sgn,
                        input bit so);
    cmp_valid = 1'b1; cmp_field = 3'(fld); cmp_a = a; cmp_b = b; cmp_imm = imm;
    cmp_use_imm = use_imm; cmp_signed = sgn; xer_so = so;
  endtask

  logic [31:0] vals [8];

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_1234;
    vals[6] = 32'hFFFF_8000; vals[7] = 32'h0000_8000;
    rst_n = 1'b0; idle(); cmp_signed = 0; cmp_use_imm = 0; cmp_field = 0;
    cmp_a = 0; cmp_b = 0; cmp_imm = 0; rec_result = 0; xer_so = 0;
    mt_mask = 0; mt_value = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", cr_out, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", cr_out, 32'h0);
    exp_cr = '0;

    // R9 / R2: move-to all fields, then a partial mask (bit 0 = top nibble)
    mt_valid = 1; mt_mask = 8'hFF; mt_value = 32'h5A3C_96E1; step(); idle();
    exp_cr = 32'h5A3C_96E1;
    chk("R9 full mask", cr_out, exp_cr);
    mt_valid = 1; mt_mask = 8'h81; mt_value = 32'hFFFF_FFFF; step(); idle();
    exp_cr = 32'hFA3C_96EF;
    chk("R2/R9 mask bits 0 and 7", cr_out, exp_cr);

    // R10: nothing visible before the edge
    do_cmp(2, 32'd3, 32'd9, 16'd0, 0, 1, 0);
    #1 chk("R10 before edge", cr_out, exp_cr);
    step(); idle();
    exp_cr = put_f(exp_cr, 2, 4'b1000);
    chk("R10 after edge", cr_out, exp_cr);

    // R3 R4 R5 R6 R12: operand sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int m = 0; m < 4; m++) begin
          bit sgn, ui, so;
          int fld;
          logic [31:0] bval;
          sgn = m[0]; ui = m[1];
          fld = (i + j + m) % 8;
          so = ((i * 3 + j + m) >> 1) & 1;
          bval = ui ? ~vals[j] : vals[j];
          do_cmp(fld, vals[i], bval, vals[j][15:0], ui, sgn, so);
          step(); idle();
          exp_cr = put_f(exp_cr, fld, model_cmp(vals[i], bval, vals[j][15:0], ui, sgn, so));
          chk($sformatf("%s%s R6 R12 a=%h b=%h f=%0d", sgn ? "R3" : "R4",
                        ui ? " R5" : "", vals[i], bval, fld), cr_out, exp_cr);
        end
      end
    end

    // R7: record-form results into field 0
    for (int k = 0; k < 8; k++) begin
      rec_valid = 1; rec_result = vals[k]; xer_so = k[0]; step(); idle();
      exp_cr = put_f(exp_cr, 0, model_rec(vals[k], k[0]));
      chk($sformatf("R7 result=%h", vals[k]), cr_out, exp_cr);
    end

    // R8: compare beats record on field 0; disjoint targets both land
    do_cmp(0, 32'd1, 32'd2, 16'd0, 0, 1, 1);
    rec_valid = 1; rec_result = 32'd0; step(); idle();
    exp_cr = put_f(exp_cr, 0, 4'b1001);
    chk("R8 compare wins field 0", cr_out, exp_cr);
    do_cmp(3, 32'd5, 32'd5, 16'd0, 0, 1, 1);
    rec_valid = 1; rec_result = 32'hFFFF_FFF9; step(); idle();
    exp_cr = put_f(put_f(exp_cr, 3, 4'b0011), 0, 4'b1001);
    chk("R8 both applied", cr_out, exp_cr);

    // R9: compare and record override move-to on the same field
    mt_valid = 1; mt_mask = 8'hFF; mt_value = 32'h0;
    do_cmp(5, 32'd9, 32'd3, 16'd0, 0, 0, 0); step(); idle();
    exp_cr = put_f(32'h0, 5, 4'b0100);
    chk("R9 compare over move", cr_out, exp_cr);
    mt_valid = 1; mt_mask = 8'h01; mt_value = 32'hFFFF_FFFF;
    rec_valid = 1; rec_result = 32'd3; xer_so = 0; step(); idle();
    exp_cr = put_f(exp_cr, 0, 4'b0100);
    chk("R9 record over move", cr_out, exp_cr);

    // R10: hold while idle
    for (int k = 0; k < 4; k++) begin
      xer_so = k[0]; step();
      chk("R10 hold", cr_out, exp_cr);
    end

    // R11: read ports
    mt_valid = 1; mt_mask = 8'hFF; mt_value = 32'h1357_9BDF; step(); idle();
    exp_cr = 32'h1357_9BDF;
    for (int s = 0; s < 8; s++) begin
      rd_sel = {3'(7 - s), 3'(s)};
      #1;
      chk($sformatf("R11 port0 sel=%0d", s), {28'b0, rd_field[3:0]}, {28'b0, get_f(exp_cr, s)});
      chk($sformatf("R11 port1 sel=%0d", 7 - s), {28'b0, rd_field[7:4]},
          {28'b0, get_f(exp_cr, 7 - s)});
    end

    summary();
  end

endmodule